// File: doc/BRIEF.md
# Load/Store Alignment and Routing Unit

This unit sits between a 32-bit little-endian core's execute stage and its data memory port. For each request it adds a signed 16-bit offset to a base register value to form the byte address. It checks that the address suits the access width and turns the width and the low address bits into four lane enables. For stores it moves the source operand into the lanes being written.

The request is registered once and presented to memory on the next cycle. In that same cycle the unit takes the word the memory returns, picks out the addressed byte or halfword, and widens it to 32 bits with sign or zero fill.

The unit also decides where the access goes. Three independent conditions send it past the data cache:
- the request is an uncached I/O variant;
- address bit 31 is set;
- the address falls inside a tightly coupled memory window, which has a parameterised base and size.

A window hit is also flagged separately, so that the access can be steered to that memory.

Top module: `lsu_align_route`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. It appears on `mem_addr` in the cycle after `req_valid` is sampled high.
- R2: `req_size` encodes the access width as 0 = byte, 1 = halfword and 2 = word; code 3 is treated as word. Bit k of `mem_be` enables byte lane k, which is data bits 8k+7..8k; lane 0 is the lowest address. For a correctly aligned access:
  - a byte access enables only the lane given by address bits 1:0;
  - a halfword access enables lanes 1:0 when address bit 1 is 0, and lanes 3:2 when it is 1;
  - a word access enables all four lanes.
- R3: A halfword access with address bit 0 set, or a word access with address bits 1:0 non-zero, is misaligned. A misaligned access raises `mis_err` for one cycle, with `mem_valid` low, `mem_be` zero and `load_result` zero.
- R4: For an aligned store, `mem_write` is 1 and the data is placed as follows, with all other lanes zero:
  - a byte store places the source's bits 7:0 in the enabled lane;
  - a halfword store places bits 15:0 in the two enabled lanes;
  - a word store passes the source through unchanged.
  
  For a load, `mem_write` is 0 and `mem_wdata` is zero.
- R5: For an aligned signed load (`req_unsigned` = 0), `load_result` is the addressed byte or halfword of `mem_rdata`, sign-extended to 32 bits. A word load returns `mem_rdata` unchanged.
- R6: For an aligned unsigned load (`req_unsigned` = 1), `load_result` is the addressed byte or halfword, zero-extended.
- R7: A request with `req_io` = 1 gives `mem_cacheable` = 0.
- R8: An access whose address has bit 31 set gives `mem_cacheable` = 0.
- R9: An address A with TCM_BASE <= A < TCM_BASE + TCM_BYTES gives `mem_tcm_hit` = 1 and `mem_cacheable` = 0. An address outside that range gives `mem_tcm_hit` = 0.
- R10: After reset, and in any cycle following a cycle with no request, all of the following are zero: `mem_valid`, `mem_write`, `mem_be`, `mem_wdata`, `mis_err`, `mem_cacheable`, `mem_tcm_hit` and `load_result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_load | input | 1 | 1 = load, 0 = store |
| req_size | input | 2 | Width: 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend narrow loads |
| req_io | input | 1 | Uncached I/O variant |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed byte offset |
| req_wsrc | input | 32 | Store source register |
| mem_rdata | input | 32 | Read word returned for the presented access |
| mem_valid | output | 1 | Aligned access presented to memory |
| mem_write | output | 1 | Presented access is a store |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_cacheable | output | 1 | Access may use the data cache |
| mem_tcm_hit | output | 1 | Address inside the tightly coupled window |
| mis_err | output | 1 | Misaligned access rejected |
| load_result | output | 32 | Extracted and extended load value |

## Verification
The bench builds the unit with `TCM_BASE` = 0x1000 and `TCM_BYTES` = 0x100, a window small enough that both of its edges and the words just outside it are tested directly. It sweeps every combination of the following, each against three data patterns chosen so that the top bit of every byte and halfword is tried both set and clear:
- all three widths;
- all four low address bits;
- load and store;
- signed and unsigned.

The base and offset pair used in the sweep includes a negative offset. Separate accesses test offsets at both ends of the 16-bit range, the bit 31 boundary and the I/O bypass.

// File: rtl/lsu_pkg.sv
// Shared widths and the access-width encoding of the load/store alignment unit.
// Assumes a 32-bit little-endian data path split into 8-bit lanes.
package lsu_pkg;
    localparam int XLEN   = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = XLEN / LANE_W;
    localparam int LO_W   = $clog2(LANES);
    localparam int HALF_W = 2 * LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } lsu_size_e;
endpackage

// File: rtl/lsu_agen.sv
// Address generation: forms the effective address, flags misalignment and
// derives one enable per byte lane. Purely combinational.
// Assumes: size code 3 behaves as a word access.
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int OFFS_W = 16
) (
    input  logic [XLEN-1:0]  base,
    input  logic [OFFS_W-1:0] offset,
    input  lsu_size_e        size,
    output logic [XLEN-1:0]  ea,
    output logic             misaligned,
    output logic [LANES-1:0] lane_en
);
    logic [LO_W-1:0] lo;

    // Effective address: base plus sign-extended offset.
    always_comb ea = base + {{(XLEN-OFFS_W){offset[OFFS_W-1]}}, offset};

    assign lo = ea[LO_W-1:0];

    // Alignment rule per access width.
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = lo[0];
            default: misaligned = |lo;
        endcase
    end

    // One enable per lane, suppressed on a misaligned access.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LO_W-1:0] LANE_IDX = LO_W'(g);
        logic hit;

        // Does this lane belong to the addressed unit?
        always_comb begin
            case (size)
                SZ_BYTE: hit = (lo == LANE_IDX);
                SZ_HALF: hit = (lo[LO_W-1] == LANE_IDX[LO_W-1]);
                default: hit = 1'b1;
            endcase
        end

        assign lane_en[g] = hit & ~misaligned;
    end
endmodule

// File: rtl/lsu_store_steer.sv
// Store data steering: places the low byte, low halfword or full word of the
// source into the enabled lanes and zeroes every other lane.
// Assumes lane_en already reflects width and alignment.
module lsu_store_steer
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]  src,
    input  lsu_size_e        size,
    input  logic [LANES-1:0] lane_en,
    input  logic             store_en,
    output logic [XLEN-1:0]  wdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] pick;

        // Choose which source byte lands in lane g.
        always_comb begin
            case (size)
                SZ_BYTE: pick = src[LANE_W-1:0];
                SZ_HALF: pick = src[(g % 2)*LANE_W +: LANE_W];
                default: pick = src[g*LANE_W +: LANE_W];
            endcase
        end

        assign wdata[g*LANE_W +: LANE_W] = (store_en && lane_en[g]) ? pick : '0;
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load data extraction: selects the addressed byte or halfword of the read
// word and widens it with sign or zero fill. Output is zero when not enabled.
// Assumes the access was aligned when enable is high.
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0] rdata,
    input  logic [LO_W-1:0] lo,
    input  lsu_size_e       size,
    input  logic            is_unsigned,
    input  logic            enable,
    output logic [XLEN-1:0] result
);
    logic [LANE_W-1:0] byte_sel;
    logic [HALF_W-1:0] half_sel;
    logic [XLEN-1:0]   widened;

    // Lane selection by low address bits.
    always_comb begin
        byte_sel = rdata[{lo, 3'b000} +: LANE_W];
        half_sel = rdata[{lo[LO_W-1], 4'b0000} +: HALF_W];
    end

    // Width-dependent sign or zero extension.
    always_comb begin
        case (size)
            SZ_BYTE: widened = {{(XLEN-LANE_W){~is_unsigned & byte_sel[LANE_W-1]}}, byte_sel};
            SZ_HALF: widened = {{(XLEN-HALF_W){~is_unsigned & half_sel[HALF_W-1]}}, half_sel};
            default: widened = rdata;
        endcase
    end

    // Gate the result so idle or rejected cycles read as zero.
    always_comb result = enable ? widened : '0;
endmodule

// File: rtl/lsu_route_decode.sv
// Routing decode: decides whether an access may be cached and whether it
// targets the tightly coupled window. Three bypass causes are ORed.
// Assumes TCM_BASE + TCM_BYTES fits in 33 bits (it always does).
module lsu_route_decode
    import lsu_pkg::*;
#(
    parameter logic [XLEN-1:0] TCM_BASE  = 32'h0000_1000,
    parameter logic [XLEN-1:0] TCM_BYTES = 32'h0000_0100
) (
    input  logic [XLEN-1:0] ea,
    input  logic            io_req,
    output logic            in_tcm,
    output logic            cacheable
);
    localparam logic [XLEN:0] WIN_LO = {1'b0, TCM_BASE};
    localparam logic [XLEN:0] WIN_HI = {1'b0, TCM_BASE} + {1'b0, TCM_BYTES};

    // Half-open window compare done one bit wider to avoid wrap.
    always_comb in_tcm = ({1'b0, ea} >= WIN_LO) && ({1'b0, ea} < WIN_HI);

    // Any of I/O variant, high address bit or window hit bypasses the cache.
    always_comb cacheable = ~(io_req | ea[XLEN-1] | in_tcm);
endmodule

// File: rtl/lsu_align_route.sv
// Top of the load/store alignment and routing unit. Registers one request
// and presents address, lane enables, steered store data and routing flags
// to memory a cycle later; extracts the load value from the read word
// returned in that presentation cycle.
// Assumes memory returns read data combinationally for the presented access.
module lsu_align_route
    import lsu_pkg::*;
#(
    parameter int              OFFS_W    = 16,
    parameter logic [31:0]     TCM_BASE  = 32'h0000_1000,
    parameter logic [31:0]     TCM_BYTES = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_load,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic              req_io,
    input  logic [31:0]       req_base,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [31:0]       req_wsrc,
    input  logic [31:0]       mem_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              mem_cacheable,
    output logic              mem_tcm_hit,
    output logic              mis_err,
    output logic [31:0]       load_result
);
    lsu_size_e        size_in;
    logic [XLEN-1:0]  ea;
    logic             misaligned;
    logic [LANES-1:0] lane_en;
    logic [XLEN-1:0]  steered;
    logic             in_tcm;
    logic             cacheable;
    logic             accept;

    // Registered request fields used by load extraction.
    logic [LO_W-1:0]  lo_q;
    lsu_size_e        size_q;
    logic             uns_q;
    logic             load_q;

    assign size_in = lsu_size_e'(req_size);
    assign accept  = req_valid & ~misaligned;

    lsu_agen #(.OFFS_W(OFFS_W)) agen_i (
        .base       (req_base),
        .offset     (req_offset),
        .size       (size_in),
        .ea         (ea),
        .misaligned (misaligned),
        .lane_en    (lane_en)
    );

    lsu_store_steer steer_i (
        .src      (req_wsrc),
        .size     (size_in),
        .lane_en  (lane_en),
        .store_en (req_valid & ~req_load),
        .wdata    (steered)
    );

    lsu_route_decode #(.TCM_BASE(TCM_BASE), .TCM_BYTES(TCM_BYTES)) route_i (
        .ea        (ea),
        .io_req    (req_io),
        .in_tcm    (in_tcm),
        .cacheable (cacheable)
    );

    // Presentation register: captures one request per cycle, clears when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid     <= 1'b0;
            mem_write     <= 1'b0;
            mem_addr      <= '0;
            mem_be        <= '0;
            mem_wdata     <= '0;
            mem_cacheable <= 1'b0;
            mem_tcm_hit   <= 1'b0;
            mis_err       <= 1'b0;
            lo_q          <= '0;
            size_q        <= SZ_BYTE;
            uns_q         <= 1'b0;
            load_q        <= 1'b0;
        end else begin
            mem_valid     <= accept;
            mem_write     <= accept & ~req_load;
            mem_be        <= req_valid ? lane_en : '0;
            mem_wdata     <= steered;
            mem_cacheable <= accept & cacheable;
            mem_tcm_hit   <= accept & in_tcm;
            mis_err       <= req_valid & misaligned;
            load_q        <= accept & req_load;
            if (req_valid) begin
                mem_addr <= ea;
                lo_q     <= ea[LO_W-1:0];
                size_q   <= size_in;
                uns_q    <= req_unsigned;
            end
        end
    end

    lsu_load_extract extract_i (
        .rdata       (mem_rdata),
        .lo          (lo_q),
        .size        (size_q),
        .is_unsigned (uns_q),
        .enable      (load_q),
        .result      (load_result)
    );
endmodule

// File: rtl/lsu_align_route_chk.sv
// Property checker for the load/store alignment and routing unit, bound to
// the top module. Observes ports only.
module lsu_align_route_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_size,
    input logic [31:0] req_base,
    input logic [15:0] req_offset,
    input logic        mem_valid,
    input logic        mem_write,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] mem_wdata,
    input logic        mem_cacheable,
    input logic        mem_tcm_hit,
    input logic        mis_err,
    input logic [31:0] load_result
);
    logic [31:0] ea_now;
    logic [31:0] be_bits;

    assign ea_now  = req_base + {{16{req_offset[15]}}, req_offset};
    assign be_bits = {{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}};

    p_addr_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) |-> mem_addr == $past(ea_now));

    p_lane_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

    p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && $past(req_size == 2'd2) && $past(ea_now[1:0] != 2'd0)
        |-> mis_err);

    p_err_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mis_err |-> (mem_be == 4'd0 && !mem_valid && load_result == 32'd0));

    p_wdata_in_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write |-> (mem_wdata & ~be_bits) == 32'd0);

    p_high_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_addr[31] |-> !mem_cacheable);

    p_tcm_uncached_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_tcm_hit |-> !mem_cacheable);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> (mem_be == 4'd0 && !mem_write && mem_wdata == 32'd0 &&
                        !mem_cacheable && !mem_tcm_hit && load_result == 32'd0));
endmodule

bind lsu_align_route lsu_align_route_chk u_chk (.*);

// File: tb/lsu_align_route_tb_top.sv
// Self-checking bench: exhaustive width/lane/direction/sign sweep plus
// routing boundary cases, with expected values computed arithmetically.
module lsu_align_route_tb_top;
    localparam logic [31:0] T_BASE  = 32'h0000_1000;
    localparam logic [31:0] T_BYTES = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_load = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic        req_io = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wsrc = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_valid, mem_write, mem_cacheable, mem_tcm_hit, mis_err;
    logic [31:0] mem_addr, mem_wdata, load_result;
    logic [3:0]  mem_be;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lsu_align_route #(.OFFS_W(16), .TCM_BASE(T_BASE), .TCM_BYTES(T_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_load(req_load),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_io(req_io),
        .req_base(req_base), .req_offset(req_offset), .req_wsrc(req_wsrc),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_cacheable(mem_cacheable), .mem_tcm_hit(mem_tcm_hit),
        .mis_err(mis_err), .load_result(load_result)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive, let it register, return read data, compare all outputs.
    task automatic access(input bit ld, input logic [1:0] sz, input bit uns, input bit io,
                          input logic [31:0] base, input logic [15:0] off,
                          input logic [31:0] src, input logic [31:0] rd);
        logic [31:0] ea, mask, be_x, wd_x, ld_x, raw;
        int nb, lo;
        bit mis, tcm, cach;
        ea   = base + {{16{off[15]}}, off};
        nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        lo   = int'(ea[1:0]);
        mis  = (lo % nb) != 0;
        mask = 32'((64'd1 << (8 * nb)) - 64'd1);
        be_x = mis ? 32'd0 : 32'(((1 << nb) - 1) << lo);
        wd_x = (!ld && !mis) ? ((src & mask) << (8 * lo)) : 32'd0;
        raw  = (rd >> (8 * lo)) & mask;
        if (!uns && nb < 4 && raw[8 * nb - 1]) raw = raw | ~mask;
        ld_x = (ld && !mis) ? raw : 32'd0;
        tcm  = (ea >= T_BASE) && ({1'b0, ea} < {1'b0, T_BASE} + {1'b0, T_BYTES});
        cach = !mis && !(io || ea[31] || tcm);

        @(negedge clk);
        req_valid = 1'b1; req_load = ld; req_size = sz; req_unsigned = uns; req_io = io;
        req_base = base; req_offset = off; req_wsrc = src;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        mem_rdata = rd;
        #1;
        check(mem_addr == ea, "R1 address", mem_addr, ea);
        check(mis_err == mis, "R3 misalign flag", 32'(mis_err), 32'(mis));
        check(mem_valid == !mis, "R3 valid", 32'(mem_valid), 32'(!mis));
        check(mem_be == be_x[3:0], mis ? "R3 enables cleared" : "R2 enables", 32'(mem_be), be_x);
        check(mem_write == (!ld && !mis), "R4 write", 32'(mem_write), 32'(!ld && !mis));
        check(mem_wdata == wd_x, "R4 store data", mem_wdata, wd_x);
        check(load_result == ld_x, uns ? "R6 zero-extended load" : "R5 sign-extended load", load_result, ld_x);
        check(mem_tcm_hit == (tcm && !mis), "R9 window hit", 32'(mem_tcm_hit), 32'(tcm && !mis));
        check(mem_cacheable == cach, io ? "R7 io bypass" : (ea[31] ? "R8 high bypass" : "R9 cacheable"),
              32'(mem_cacheable), 32'(cach));
    endtask

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h8091_A2F3;
        pats[1] = 32'h7F01_6E12;
        pats[2] = 32'hC3FF_0080;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check(!mem_valid && !mis_err && mem_be == 0 && !mem_write, "R10 reset control", 32'(mem_be), 32'd0);
        check(!mem_cacheable && !mem_tcm_hit && load_result == 0 && mem_wdata == 0,
              "R10 reset data", load_result, 32'd0);

        // Exhaustive sweep: width x low bits x direction x signedness x pattern.
        for (int sz = 0; sz < 3; sz++)
            for (int lo = 0; lo < 4; lo++)
                for (int ld = 0; ld < 2; ld++)
                    for (int un = 0; un < 2; un++)
                        for (int p = 0; p < 3; p++)
                            access(ld[0], 2'(sz), un[0], 1'b0, 32'h0000_2010,
                                   16'(lo - 16), pats[p], pats[(p + 1) % 3]);

        // R1: offset extremes.
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h0001_0000, 16'h7FFC, 32'd0, 32'h1234_5678);
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h0001_0000, 16'h8000, 32'd0, 32'h1234_5678);
        // R7: I/O variant bypasses.
        access(1'b0, 2'd2, 1'b0, 1'b1, 32'h0000_2000, 16'h0000, 32'hDEAD_BEEF, 32'd0);
        access(1'b1, 2'd0, 1'b1, 1'b1, 32'h0000_2000, 16'h0003, 32'd0, 32'hAB00_0000);
        // R8: bit 31 boundary.
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h7FFF_FFFC, 16'h0000, 32'd0, 32'h0000_0001);
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h8000_0000, 16'h0000, 32'd0, 32'h0000_0001);
        access(1'b0, 2'd1, 1'b0, 1'b0, 32'hFFFF_FF00, 16'h0002, 32'h0000_BEEF, 32'd0);
        // R9: window edges.
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_0FFC, 16'h0000, 32'd0, 32'h5);
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_1000, 16'h0000, 32'd0, 32'h5);
        access(1'b0, 2'd0, 1'b0, 1'b0, 32'h0000_10FC, 16'h0003, 32'h0000_0077, 32'd0);
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_1100, 16'h0000, 32'd0, 32'h5);
        access(1'b1, 2'd2, 1'b0, 1'b0, 32'h0000_1104, 16'hFFFC, 32'd0, 32'h5);

        // R10: idle cycle after activity.
        @(posedge clk);
        @(negedge clk);
        #1;
        check(!mem_valid && !mis_err && mem_be == 0 && !mem_write, "R10 idle control", 32'(mem_be), 32'd0);
        check(!mem_cacheable && !mem_tcm_hit && load_result == 0 && mem_wdata == 0,
              "R10 idle data", load_result, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule